// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the command register a processor writes to send an interrupt to another processor. The register is split into two 32-bit halves behind a simple register port. Software writes the high half first, with the destination identifier in bits 31:24. Then it writes the low half, which holds the vector and the delivery-mode field. Only the low-half write starts a send. At that moment the block captures `{destination, vector}` into an outgoing message and offers it on a valid/ready output.

A delivery-status bit in the low-half readback shows busy from the cycle after launch until the cycle after the message is taken downstream. The bit then shows idle again. Software polls this bit before it writes a new command. If a low-half write arrives while a send is still in flight, the block discards it and sets a sticky error bit. The outgoing message follows the usual stream rules. `msg_valid` stays high, and `msg_data` does not change, until `msg_ready` is seen high on a clock edge. The downstream side may hold `msg_ready` low for any number of cycles.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, both halves read as zero, the delivery status (low readback bit 12) is idle (0), the error bit (low readback bit 13) is 0, and `msg_valid` is low.
- R2: A write to the high half (address 1) replaces all 32 bits of it. The new value reads back in full at address 1. This write never raises `msg_valid`.
- R3: A write to the low half (address 0) while idle stores bits 10:0 and raises `msg_valid` on the next cycle. It carries `msg_data = {high[31:24], wr_data[7:0]}`. Low readback bits 11 and 31:14 are always 0.
- R4: The status bit reads 1 from the cycle after launch until the clock edge on which `msg_valid` and `msg_ready` are both high. It reads 0 from the next cycle on, and `msg_valid` falls at the same time.
- R5: While `msg_ready` is low, `msg_valid` stays high and `msg_data` holds its value.
- R6: A low-half write made while busy is dropped. The stored low bits and the message are unchanged, and the error bit is set. The error bit stays set until reset.
- R7: A low-half write made in the same cycle as the acceptance of the pending message is still dropped, and it sets the error bit.
- R8: A high-half write made while busy updates the register but not the in-flight `msg_data`. The next launch carries the new destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low half, 1 high half |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 low half with status, 1 high half |
| rd_data | output | 32 | Combinational read data |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Downstream accepts message |
| msg_data | output | 16 | Message: destination in 15:8, vector in 7:0 |

## Verification
Two functions can meet in one cycle: the downstream acceptance that ends a send, and a new low-half write that would start the next one. The bench produces this case by raising `msg_ready` in the same cycle as the low-half write. Busy is judged by the state before the clock edge, so the write must be dropped, the error bit set, and the status idle afterwards. The bench also checks that a later write made while idle launches normally.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1
  } half_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } dlv_state_e;
endpackage

// File: rtl/ipi_half_regs.sv
module ipi_half_regs #(
  parameter int DATA_W = 32,
  parameter int LOW_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_high,
  input  logic              ld_low,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] high_q,
  output logic [LOW_W-1:0]  low_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high_q <= '0;
      low_q  <= '0;
    end else begin
      if (ld_high) high_q <= din;
      if (ld_low)  low_q  <= din[LOW_W-1:0];
    end
  end
endmodule

// File: rtl/ipi_send_ctrl.sv
module ipi_send_ctrl
  import ipi_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic low_req,
  input  logic accept,
  output logic launch,
  output logic busy,
  output logic err
);
  dlv_state_e state_q, state_d;
  logic       err_q;

  assign busy   = (state_q == ST_BUSY);
  assign launch = low_req && (state_q == ST_IDLE);
  assign err    = err_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (low_req) state_d = ST_BUSY;
      ST_BUSY: if (accept)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (low_req && state_q == ST_BUSY) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ipi_msg_slot.sv
module ipi_msg_slot #(
  parameter int DEST_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [DEST_W-1:0]       dest_in,
  input  logic [VEC_W-1:0]        vec_in,
  output logic [DEST_W+VEC_W-1:0] msg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) msg_q <= '0;
    else if (load) msg_q <= {dest_in, vec_in};
  end
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_cmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int DEST_W   = 8,
  parameter int VEC_W    = 8,
  parameter int MODE_W   = 3,
  parameter int STAT_BIT = 12,
  parameter int ERR_BIT  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    msg_valid,
  input  logic                    msg_ready,
  output logic [DEST_W+VEC_W-1:0] msg_data
);
  localparam int DEST_LSB = DATA_W - DEST_W;
  localparam int MODE_LSB = VEC_W;
  localparam int LOW_W    = MODE_LSB + MODE_W;
  localparam logic [ADDR_W-1:0] LOW_ADDR  = ADDR_W'(SEL_LOW);
  localparam logic [ADDR_W-1:0] HIGH_ADDR = ADDR_W'(SEL_HIGH);

  logic              wr_high, wr_low, launch, busy, err;
  logic [DATA_W-1:0] high_q;
  logic [LOW_W-1:0]  low_q;

  assign wr_high = wr_en && (wr_addr == HIGH_ADDR);
  assign wr_low  = wr_en && (wr_addr == LOW_ADDR);

  ipi_send_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .low_req(wr_low),
    .accept(msg_valid && msg_ready),
    .launch(launch), .busy(busy), .err(err)
  );

  ipi_half_regs #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_high(wr_high), .ld_low(launch),
    .din(wr_data), .high_q(high_q), .low_q(low_q)
  );

  ipi_msg_slot #(.DEST_W(DEST_W), .VEC_W(VEC_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .dest_in(high_q[DATA_W-1:DEST_LSB]), .vec_in(wr_data[VEC_W-1:0]),
    .msg_q(msg_data)
  );

  assign msg_valid = busy;

  always_comb begin
    rd_data = '0;
    if (rd_addr == HIGH_ADDR) begin
      rd_data = high_q;
    end else if (rd_addr == LOW_ADDR) begin
      rd_data[LOW_W-1:0] = low_q;
      rd_data[STAT_BIT]  = busy;
      rd_data[ERR_BIT]   = err;
    end
  end
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int MSG_W  = 16,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [MSG_W-1:0]  msg_data,
  input logic              err
);
  logic low_wr, high_wr;
  assign low_wr  = wr_en && (wr_addr == ADDR_W'(0));
  assign high_wr = wr_en && (wr_addr == ADDR_W'(1));

  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_wr && !msg_valid |=> msg_valid && (msg_data[VEC_W-1:0] == $past(wr_data[VEC_W-1:0])));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data));

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_wr && msg_valid |=> err && $stable(msg_data));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_high_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    high_wr && !msg_valid |=> !msg_valid);
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MSG_W(DEST_W + VEC_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_data(msg_data), .err(err)
);

// File: tb/ipi_cmd_reg_test.sv
module ipi_cmd_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [15:0] msg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ipi_cmd_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // one write cycle; returns at the next negedge, after the edge took effect
  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic rdy);
    wr_en = 1'b1; wr_addr = a; wr_data = d; msg_ready = rdy;
    @(negedge clk);
    wr_en = 1'b0; msg_ready = 1'b0;
  endtask

  task automatic accept_now();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic do_reset();
    logic [31:0] v;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 low", v, 32'h0);
    rd(2'd1, v); check("R1 high", v, 32'h0);
    check("R1 valid", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_high_write();
    logic [31:0] v;
    wr(2'd1, 32'hA5FF_1234, 1'b0);
    rd(2'd1, v); check("R2 high full", v, 32'hA5FF_1234);
    check("R2 no launch", {31'b0, msg_valid}, 32'h0);
    wr(2'd1, 32'h3C00_0000, 1'b0);
    rd(2'd1, v); check("R2 replace", v, 32'h3C00_0000);
  endtask

  task automatic t_launch_backpressure();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_F7C1, 1'b0);
    check("R3 valid", {31'b0, msg_valid}, 32'h1);
    check("R3 data", {16'b0, msg_data}, 32'h3CC1);
    rd(2'd0, v); check("R3 R4 low busy", v, 32'h0000_17C1);
    repeat (3) @(negedge clk);
    check("R5 held valid", {31'b0, msg_valid}, 32'h1);
    check("R5 held data", {16'b0, msg_data}, 32'h3CC1);
    accept_now();
    check("R4 valid low", {31'b0, msg_valid}, 32'h0);
    rd(2'd0, v); check("R4 idle", v, 32'h0000_07C1);
  endtask

  task automatic t_busy_drop();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0222, 1'b0);
    wr(2'd0, 32'h0000_0399, 1'b0);
    check("R6 msg kept", {16'b0, msg_data}, 32'h3C22);
    rd(2'd0, v); check("R6 low kept err set", v, 32'h0000_3222);
    wr(2'd1, 32'h7700_0000, 1'b0);
    check("R8 inflight dest", {16'b0, msg_data}, 32'h3C22);
    rd(2'd1, v); check("R8 high updated", v, 32'h7700_0000);
    accept_now();
    wr(2'd0, 32'h0000_0044, 1'b0);
    check("R8 new dest", {16'b0, msg_data}, 32'h7744);
    rd(2'd0, v); check("R6 sticky", v, 32'h0000_3044);
    accept_now();
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0011, 1'b0);
    wr(2'd0, 32'h0000_0055, 1'b1);
    check("R7 valid low", {31'b0, msg_valid}, 32'h0);
    rd(2'd0, v); check("R7 dropped err", v, 32'h0000_2011);
    wr(2'd0, 32'h0000_0066, 1'b0);
    check("R7 later launch", {16'b0, msg_data}, 32'h7766);
    accept_now();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_high_write();
    t_launch_backpressure();
    t_busy_drop();
    do_reset();
    wr(2'd1, 32'h7700_0000, 1'b0);
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule